// File: doc/BRIEF.md
# Master Video Sync Pulse Generator

This block is a free-running timing master for a 50 Hz or 60 Hz video raster. A horizontal counter walks the pixel clocks of each line. A vertical counter advances in half-line steps, so that fields of a whole number of lines plus one half fall on exact counter values. From these two counters the block derives four timing signals: a vertical sync pulse, an odd/even field flag, a marker for the first field of a repeating 4-, 8- or 12-field sequence, and a horizontal pulse. The start and length of the horizontal pulse are programmable, and it can be forced active over a programmable range of half-lines to form a composite blank.

The counters advance only on cycles where the clock enable is high. A standard select picks the line length and the field length. An interlace select picks either fields of N+0.5 lines or shortened fields of N lines. In the shortened-field mode the odd/even flag is parked and the field sequence stops. Each of the four outputs passes through its own polarity inversion before it leaves the block.

Top module: `vsync_master_gen`

## Requirements
- R1: A line lasts LINE_50 clock-enabled cycles (default 1728) when `std_60` is 0 and LINE_60 (default 1716) when `std_60` is 1. The horizontal position runs 0 up to length-1 and then wraps to 0.
- R2: A field lasts HALF_50 (default 625) or HALF_60 (default 525) half-lines with `ilace`=1, and one half-line fewer with `ilace`=0. A half-line boundary falls at horizontal positions 0 and length/2.
- R3: The vertical sync is logically active during the first VS_50 (default 5) half-lines of each field in 50 Hz mode and the first VS_60 (default 6) in 60 Hz mode.
- R4: With `ilace`=1, the odd/even flag is logically low in odd fields and high in even fields, and it toggles at every field end.
- R5: With `ilace`=0, the odd/even flag is held at logic high and the field-sequence counter keeps its value.
- R6: The field-sequence marker is logically high during the first field of a repeating sequence whose length is 4, 8 or 12 fields, for `seq_sel` = 0, 1, and 2 or 3 respectively.
- R7: The horizontal pulse is logically active while start <= position < start+width. A width of 0 never asserts it.
- R8: With `blank_en`=1, the horizontal output is logically active for every clock of the half-lines whose index lies in [blank_lo, blank_hi], counted from 0 at the field start.
- R9: Setting `pol` bit 0, 1, 2 or 3 inverts the vertical sync, the odd/even flag, the sequence marker or the horizontal output, in that order.
- R10: On the first clock where `ilace` is high after having been low, the sequence restarts: the field in progress becomes field 1, with the marker high and the flag odd.
- R11: After reset the horizontal and half-line positions are 0, the field is odd and is the first of its sequence.
- R12: On cycles with `ce`=0 all timing state holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce | input | 1 | Clock enable for all counters |
| std_60 | input | 1 | 0 selects 50 Hz timing, 1 selects 60 Hz timing |
| ilace | input | 1 | 1 selects interlaced fields, 0 selects half-line-shortened fields |
| seq_sel | input | 2 | Field sequence length: 0 gives 4, 1 gives 8, 2 or 3 give 12 |
| hp_start | input | HW | First horizontal position of the horizontal pulse |
| hp_width | input | HW | Horizontal pulse length in clocks |
| blank_en | input | 1 | Enables composite-blank gating |
| blank_lo | input | VW | First half-line of the blanked range |
| blank_hi | input | VW | Last half-line of the blanked range |
| pol | input | 4 | Per-output polarity inversion |
| vs_o | output | 1 | Vertical sync |
| oe_o | output | 1 | Odd/even field flag |
| fseq_o | output | 1 | First-field-of-sequence marker |
| hsig_o | output | 1 | Horizontal pulse or composite blank |

## Verification
The bench builds the block with lines of 40 and 36 clocks and fields of 25 and 21 half-lines. The sync lengths stay at 5 and 6 half-lines and the counter widths stay at their defaults. With these values a full 12-field sequence takes only a few thousand cycles. The run can therefore reach every sequence wrap, the return from shortened fields to interlace, standard switches in mid-field and irregular clock-enable patterns, with a cycle-by-cycle comparison against an independent model.

// File: rtl/vsg_pkg.sv
// Shared definitions for the master sync generator.
// Assumes: output vector bit positions match the pol input bit order.
package vsg_pkg;
    localparam int SIG_VS   = 0;
    localparam int SIG_OE   = 1;
    localparam int SIG_FSEQ = 2;
    localparam int SIG_HSIG = 3;
    localparam int NUM_SIG  = 4;

    typedef logic [NUM_SIG-1:0] sig_vec_t;

    // Number of fields in the marker sequence for a select code.
    function automatic logic [3:0] seq_len(input logic [1:0] sel);
        case (sel)
            2'd0:    return 4'd4;
            2'd1:    return 4'd8;
            default: return 4'd12;
        endcase
    endfunction
endpackage

// File: rtl/vsg_line_timer.sv
// Horizontal counter: counts clock-enabled cycles along a line and
// flags each half-line boundary (position 0 and length/2).
// Assumes: both line lengths are even and fit in HW bits.
module vsg_line_timer #(
    parameter int HW      = 11,
    parameter int LINE_50 = 1728,
    parameter int LINE_60 = 1716
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce,
    input  logic          std_60,
    output logic [HW-1:0] hcnt,
    output logic          half_tick
);
    logic [HW-1:0] line_len;
    logic [HW-1:0] half_len;
    logic          at_end;

    // Select the line length for the active standard.
    always_comb begin
        line_len  = std_60 ? HW'(LINE_60) : HW'(LINE_50);
        half_len  = line_len >> 1;
        at_end    = hcnt >= line_len - 1'b1;
        half_tick = ce && (at_end || hcnt == half_len - 1'b1);
    end

    // Advance the horizontal position, wrapping at the line end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hcnt <= '0;
        else if (ce)
            hcnt <= at_end ? '0 : hcnt + 1'b1;
    end

    // R1
    line_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && hcnt >= line_len - 1'b1) |=> hcnt == '0);

    // R12
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce |=> $stable(hcnt));
endmodule

// File: rtl/vsg_field_timer.sv
// Vertical counter in half-line units, field parity and field-sequence
// counter. Shortened fields drop one half-line and freeze the sequence.
// Assumes: half_tick already includes the clock enable.
module vsg_field_timer #(
    parameter int VW      = 10,
    parameter int HALF_50 = 625,
    parameter int HALF_60 = 525
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          half_tick,
    input  logic          std_60,
    input  logic          ilace,
    input  logic [1:0]    seq_sel,
    output logic [VW-1:0] hl,
    output logic          odd,
    output logic          seq_first
);
    import vsg_pkg::*;

    logic [VW-1:0] field_len;
    logic          field_end;
    logic          ilace_q;
    logic          restart;
    logic [3:0]    seq_cnt;
    logic [3:0]    seq_last;

    // Field length in half-lines and field-end / restart detection.
    always_comb begin
        field_len = (std_60 ? VW'(HALF_60) : VW'(HALF_50))
                    - {{(VW-1){1'b0}}, ~ilace};
        field_end = half_tick && (hl >= field_len - 1'b1);
        restart   = ilace && !ilace_q;
        seq_last  = seq_len(seq_sel) - 4'd1;
        seq_first = seq_cnt == 4'd0;
    end

    // Advance the half-line index, wrapping at the field end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hl <= '0;
        else if (half_tick)
            hl <= field_end ? '0 : hl + 1'b1;
    end

    // Remember the previous interlace select to spot its return.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ilace_q <= 1'b0;
        else
            ilace_q <= ilace;
    end

    // Track field parity and position in the marker sequence.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            seq_cnt <= 4'd0;
            odd     <= 1'b1;
        end else if (field_end && ilace) begin
            odd     <= ~odd;
            seq_cnt <= (seq_cnt >= seq_last) ? 4'd0 : seq_cnt + 4'd1;
        end
    end

    // R2
    hl_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hl != $past(hl)) |-> $past(half_tick));

    // R4
    parity_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (field_end && ilace && !restart) |=> odd != $past(odd));

    // R5
    seq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ilace |=> $stable(seq_cnt));

    // R10
    seq_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ilace) |=> (seq_cnt == 4'd0 && odd));
endmodule

// File: rtl/vsg_out_stage.sv
// Decodes the counters into the four timing signals, applies the
// composite-blank gating and the per-output polarity.
// Assumes: blank range bounds are half-line indices within the field.
module vsg_out_stage #(
    parameter int HW    = 11,
    parameter int VW    = 10,
    parameter int VS_50 = 5,
    parameter int VS_60 = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [HW-1:0]          hcnt,
    input  logic [VW-1:0]          hl,
    input  logic                   std_60,
    input  logic                   ilace,
    input  logic                   odd,
    input  logic                   seq_first,
    input  logic [HW-1:0]          hp_start,
    input  logic [HW-1:0]          hp_width,
    input  logic                   blank_en,
    input  logic [VW-1:0]          blank_lo,
    input  logic [VW-1:0]          blank_hi,
    input  logic [vsg_pkg::NUM_SIG-1:0] pol,
    output logic [vsg_pkg::NUM_SIG-1:0] sig_o
);
    import vsg_pkg::*;

    logic [HW:0]   hp_end;
    logic          hp_on;
    logic          in_blank;
    logic [VW-1:0] vs_len;
    sig_vec_t      act;

    // Window decodes for the horizontal pulse and the blank range.
    always_comb begin
        hp_end   = {1'b0, hp_start} + {1'b0, hp_width};
        hp_on    = ({1'b0, hcnt} >= {1'b0, hp_start}) && ({1'b0, hcnt} < hp_end);
        in_blank = blank_en && (hl >= blank_lo) && (hl <= blank_hi);
        vs_len   = std_60 ? VW'(VS_60) : VW'(VS_50);
    end

    // Logical (active-high) value of each timing signal.
    always_comb begin
        act[SIG_VS]   = hl < vs_len;
        act[SIG_OE]   = ilace ? ~odd : 1'b1;
        act[SIG_FSEQ] = seq_first;
        act[SIG_HSIG] = in_blank || hp_on;
    end

    // Per-output polarity inversion.
    for (genvar i = 0; i < NUM_SIG; i++) begin : g_pol
        assign sig_o[i] = act[i] ^ pol[i];
    end

    // R8
    blank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_blank |-> sig_o[SIG_HSIG] == ~pol[SIG_HSIG]);

    // R7
    zero_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hp_width == '0 && !in_blank) |-> sig_o[SIG_HSIG] == pol[SIG_HSIG]);

    // R5
    oe_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ilace |-> sig_o[SIG_OE] == ~pol[SIG_OE]);
endmodule

// File: rtl/vsync_master_gen.sv
// Top of the master sync generator: line timer, field timer and
// output stage. All state is reset synchronously by rst_n.
// Assumes: line lengths are even; field lengths are odd half-line counts.
module vsync_master_gen #(
    parameter int HW      = 11,
    parameter int VW      = 10,
    parameter int LINE_50 = 1728,
    parameter int LINE_60 = 1716,
    parameter int HALF_50 = 625,
    parameter int HALF_60 = 525,
    parameter int VS_50   = 5,
    parameter int VS_60   = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce,
    input  logic          std_60,
    input  logic          ilace,
    input  logic [1:0]    seq_sel,
    input  logic [HW-1:0] hp_start,
    input  logic [HW-1:0] hp_width,
    input  logic          blank_en,
    input  logic [VW-1:0] blank_lo,
    input  logic [VW-1:0] blank_hi,
    input  logic [3:0]    pol,
    output logic          vs_o,
    output logic          oe_o,
    output logic          fseq_o,
    output logic          hsig_o
);
    import vsg_pkg::*;

    logic [HW-1:0] hcnt;
    logic          half_tick;
    logic [VW-1:0] hl;
    logic          odd;
    logic          seq_first;
    sig_vec_t      sig;

    vsg_line_timer #(.HW(HW), .LINE_50(LINE_50), .LINE_60(LINE_60)) u_line (
        .clk(clk), .rst_n(rst_n), .ce(ce), .std_60(std_60),
        .hcnt(hcnt), .half_tick(half_tick)
    );

    vsg_field_timer #(.VW(VW), .HALF_50(HALF_50), .HALF_60(HALF_60)) u_field (
        .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .std_60(std_60),
        .ilace(ilace), .seq_sel(seq_sel), .hl(hl), .odd(odd),
        .seq_first(seq_first)
    );

    vsg_out_stage #(.HW(HW), .VW(VW), .VS_50(VS_50), .VS_60(VS_60)) u_out (
        .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .hl(hl), .std_60(std_60),
        .ilace(ilace), .odd(odd), .seq_first(seq_first),
        .hp_start(hp_start), .hp_width(hp_width), .blank_en(blank_en),
        .blank_lo(blank_lo), .blank_hi(blank_hi), .pol(pol), .sig_o(sig)
    );

    // Route the polarity-adjusted vector to the named outputs.
    always_comb begin
        vs_o   = sig[SIG_VS];
        oe_o   = sig[SIG_OE];
        fseq_o = sig[SIG_FSEQ];
        hsig_o = sig[SIG_HSIG];
    end
endmodule

// File: tb/vsync_master_gen_bench.sv
module vsync_master_gen_bench;
    localparam int L50 = 40, L60 = 36, H50 = 25, H60 = 21, V50 = 5, V60 = 6;

    logic clk = 0, rst_n = 0, ce = 1, std_60 = 0, ilace = 1, blank_en = 0;
    logic [1:0]  seq_sel = 0;
    logic [10:0] hp_start = 0, hp_width = 1;
    logic [9:0]  blank_lo = 0, blank_hi = 0;
    logic [3:0]  pol = 0;
    logic vs_o, oe_o, fseq_o, hsig_o;

    always #5 clk = ~clk;

    vsync_master_gen #(.LINE_50(L50), .LINE_60(L60), .HALF_50(H50),
                       .HALF_60(H60), .VS_50(V50), .VS_60(V60)) u_vsync_master_gen (
        .clk(clk), .rst_n(rst_n), .ce(ce), .std_60(std_60), .ilace(ilace),
        .seq_sel(seq_sel), .hp_start(hp_start), .hp_width(hp_width),
        .blank_en(blank_en), .blank_lo(blank_lo), .blank_hi(blank_hi),
        .pol(pol), .vs_o(vs_o), .oe_o(oe_o), .fseq_o(fseq_o), .hsig_o(hsig_o)
    );

    typedef struct {int hc; int hl; bit odd; int seq;} exp_t;
    exp_t exp_q[$];
    int checks = 0, errors = 0;
    bit done = 0;
    int m_hc, m_hl, m_seq;
    bit m_odd, m_ilq;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Reference model: pushes the expected counter state after each edge.
    always @(posedge clk) begin : model_p
        int line, fl, sl;
        bit tick, fend, rs;
        if (!rst_n) begin
            m_hc = 0; m_hl = 0; m_odd = 1; m_seq = 0; m_ilq = 0;
        end else begin
            rs = ilace && !m_ilq;
            m_ilq = ilace;
            fend = 0;
            if (ce) begin
                line = std_60 ? L60 : L50;
                tick = (m_hc == line / 2 - 1) || (m_hc >= line - 1);
                m_hc = (m_hc >= line - 1) ? 0 : m_hc + 1;
                if (tick) begin
                    fl = (std_60 ? H60 : H50) - (ilace ? 0 : 1);
                    if (m_hl >= fl - 1) begin m_hl = 0; fend = 1; end
                    else m_hl++;
                end
            end
            sl = (seq_sel == 0) ? 4 : (seq_sel == 1) ? 8 : 12;
            if (rs) begin m_seq = 0; m_odd = 1; end
            else if (fend && ilace) begin
                m_odd = !m_odd;
                m_seq = (m_seq >= sl - 1) ? 0 : m_seq + 1;
            end
        end
        exp_q.push_back('{m_hc, m_hl, m_odd, m_seq});
    end

    // Monitor: pops the expected state and compares all four outputs.
    always @(negedge clk) begin : mon_p
        exp_t e;
        bit ve, oe, fe, he, bl, hp;
        string t;
        if (exp_q.size() > 0 && !done) begin
            e  = exp_q.pop_front();
            t  = (pol != 0) ? " R9" : "";
            ve = (e.hl < (std_60 ? V60 : V50)) ^ pol[0];
            oe = (ilace ? !e.odd : 1'b1) ^ pol[1];
            fe = (e.seq == 0) ^ pol[2];
            bl = blank_en && e.hl >= int'(blank_lo) && e.hl <= int'(blank_hi);
            hp = e.hc >= int'(hp_start) && e.hc < int'(hp_start) + int'(hp_width);
            he = (bl || hp) ^ pol[3];
            check(vs_o === ve, {"R3 vsync", t}, int'(vs_o), int'(ve));
            check(oe_o === oe, {ilace ? "R4 odd/even" : "R5 odd/even", t}, int'(oe_o), int'(oe));
            check(fseq_o === fe, {ilace ? "R6 sequence" : "R5 sequence", t}, int'(fseq_o), int'(fe));
            check(hsig_o === he, {bl ? "R8 blank" : "R7 hpulse", t}, int'(hsig_o), int'(he));
        end
    end

    task automatic drive_edge();
        @(posedge clk);
        #1;
    endtask

    // Clocks between two rising edges of hsig_o (sel=0) or vs_o (sel=1).
    task automatic rise_gap(input bit sel, output int n);
        bit p, c, r;
        int k;
        p = sel ? vs_o : hsig_o;
        do begin
            @(negedge clk); c = sel ? vs_o : hsig_o; r = c && !p; p = c;
        end while (!r);
        k = 0;
        do begin
            @(negedge clk); k++; c = sel ? vs_o : hsig_o; r = c && !p; p = c;
        end while (!r);
        n = k;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin : watchdog_p
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_run();
    end

    initial begin : main_p
        int n;
        logic [3:0] snap;
        bit f0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R11: reset state, logical polarity
        check(vs_o == 1, "R11 vsync after reset", vs_o, 1);
        check(oe_o == 0, "R11 odd field after reset", oe_o, 0);
        check(fseq_o == 1, "R11 first field after reset", fseq_o, 1);
        check(hsig_o == 1, "R11 position 0 after reset", hsig_o, 1);
        rise_gap(0, n); check(n == L50, "R1 line length 50", n, L50);
        rise_gap(1, n); check(n == H50 * (L50 / 2), "R2 field 50 interlaced", n, H50 * (L50 / 2));
        repeat (2500) @(negedge clk);

        drive_edge();
        hp_start = 7; hp_width = 9; blank_en = 1; blank_lo = 2; blank_hi = 8;
        repeat (1200) @(negedge clk);

        drive_edge();
        blank_en = 0; hp_width = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            check(hsig_o == 0, "R7 zero width", hsig_o, 0);
        end

        drive_edge();
        ce = 0; hp_width = 3;
        @(negedge clk);
        snap = {vs_o, oe_o, fseq_o, hsig_o};
        repeat (6) @(negedge clk);
        check({vs_o, oe_o, fseq_o, hsig_o} == snap, "R12 frozen outputs",
              {vs_o, oe_o, fseq_o, hsig_o}, snap);
        for (int i = 0; i < 800; i++) begin
            drive_edge();
            ce = ($urandom % 3) != 0;
        end
        drive_edge();
        ce = 1;

        drive_edge();
        std_60 = 1; seq_sel = 1; pol = 4'hF; hp_start = 3; hp_width = 4;
        rise_gap(0, n); check(n == L60, "R1 line length 60 R9", n, L60);
        rise_gap(1, n); check(n == H60 * (L60 / 2), "R2 field 60 interlaced R9", n, H60 * (L60 / 2));
        repeat (3200) @(negedge clk);

        drive_edge();
        pol = 0; seq_sel = 2; ilace = 0;
        repeat (2) @(negedge clk);
        check(oe_o == 1, "R5 odd/even parked", oe_o, 1);
        f0 = fseq_o;
        rise_gap(1, n); check(n == (H60 - 1) * (L60 / 2), "R2 field 60 shortened", n, (H60 - 1) * (L60 / 2));
        repeat (1100) @(negedge clk);
        check(fseq_o == f0, "R5 sequence held", fseq_o, f0);

        drive_edge();
        ilace = 1;
        repeat (2) @(negedge clk);
        check(fseq_o == 1, "R10 restart marker", fseq_o, 1);
        check(oe_o == 0, "R10 restart odd", oe_o, 0);
        repeat (12 * 378 + 400) @(negedge clk);

        drive_edge();
        std_60 = 0; seq_sel = 3;
        repeat (6600) @(negedge clk);
        drive_edge();
        ilace = 0;
        rise_gap(1, n); check(n == (H50 - 1) * (L50 / 2), "R2 field 50 shortened", n, (H50 - 1) * (L50 / 2));
        finish_run();
    end
endmodule